// File: doc/BRIEF.md
# Bursting Write Byte-Enable Protocol Monitor

This block is a passive observer placed on a memory-mapped slave port that accepts
bursts, at either 64 or 128 bits of data. It watches the master's read, write,
address, burst length, write data, byte lanes and the slave's stall signal. It
drives nothing on the bus. It follows where each accepted write beat sits inside
its burst, and it judges the byte-lane pattern allowed at that position. On the
wide port it also checks that lanes are enabled in whole 32-bit words and that the
enabled words form one unbroken run.

A second rule set covers stalls. While the slave holds the stall signal high
against a pending request, the master must present exactly the same request in
the next cycle. Every rule has its own sticky flag. A flag sets in the cycle after
the offending cycle and clears only on synchronous reset. A one-cycle pulse marks
each cycle in which at least one rule was broken.

Top module: `burst_be_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all five flags and `err_pulse` are 0 after that edge.
- R2: A write beat is accepted only when `mon_write` is 1 and `mon_waitreq` is 0. The first accepted beat loads the beat count from `mon_burstcnt`, with 0 treated as 1. Each later accepted beat counts down by one. A length of 1 makes that beat both first and last, so the next accepted beat starts a new burst.
- R3: An accepted beat that is neither first nor last in its burst must have every `mon_be` bit set. Otherwise `err_mid_beat` sets.
- R4: Partial lane patterns on the first or last beat of a burst set no flag, provided they obey R5 to R7.
- R5: An accepted write beat with `mon_be` equal to 0 sets `err_zero_be`.
- R6: On the 128-bit port, lane bits [4k+3:4k] form word k. An accepted beat in which any word is partly enabled sets `err_dword_split`.
- R7: On the 128-bit port, a word counts as enabled if any of its lanes is set. An accepted beat whose enabled words are nonzero and form more than one run sets `err_noncontig`. Legal word masks are 0001, 0010, 0100, 1000, 0011, 0110, 1100, 0111, 1110 and 1111.
- R8: If a cycle has `mon_waitreq` high with a read or write request, the next cycle must repeat `mon_read`, `mon_write`, `mon_addr`, `mon_burstcnt`, `mon_wdata` and `mon_be`. Any difference sets `err_stall_change`.
- R9: With `DATA_W` = 64, `err_dword_split` and `err_noncontig` never set, whatever the lane pattern.
- R10: Once set, a flag stays 1 until reset, through idle cycles and through legal traffic.
- R11: `err_pulse` is 1 for exactly the cycle after each cycle that broke any rule, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_read | input | 1 | Observed read request |
| mon_write | input | 1 | Observed write request |
| mon_addr | input | ADDR_W | Observed address |
| mon_burstcnt | input | BURST_W | Observed burst length in beats |
| mon_wdata | input | DATA_W | Observed write data |
| mon_be | input | DATA_W/8 | Observed byte enables |
| mon_waitreq | input | 1 | Observed slave stall |
| err_mid_beat | output | 1 | Sticky: partial lanes on an inner beat |
| err_dword_split | output | 1 | Sticky: a 32-bit word partly enabled |
| err_noncontig | output | 1 | Sticky: enabled words not one run |
| err_stall_change | output | 1 | Sticky: request changed while stalled |
| err_zero_be | output | 1 | Sticky: accepted write with no lanes |
| err_pulse | output | 1 | One cycle per violating cycle |

## Verification
The bench builds two copies of the monitor. The first uses `DATA_W` = 128, which
brings the word-granularity and contiguity rules, their legal mask set, and
multi-beat bursts with stalls inside them within reach. The second uses `DATA_W` = 64.
With it the bench shows that scattered lane patterns, which would break R6 or R7
on the wide port, raise nothing, while the inner-beat rule still fires. Both copies
use `BURST_W` = 8 and `ADDR_W` = 32. Lengths of 1, 2, 3 and 4 beats cover the
first-equals-last case and the inner-beat case.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

  localparam int MAX_BE = 32;
  localparam int MAX_DW = MAX_BE / 4;

  // One bit per 32-bit word: set when any lane of that word is enabled.
  function automatic logic [MAX_DW-1:0] word_any(input logic [MAX_BE-1:0] be);
    logic [MAX_DW-1:0] m;
    for (int k = 0; k < MAX_DW; k++) m[k] = |be[4*k +: 4];
    return m;
  endfunction

  // True when some word has a mix of enabled and disabled lanes.
  function automatic logic word_split(input logic [MAX_BE-1:0] be);
    logic bad;
    bad = 1'b0;
    for (int k = 0; k < MAX_DW; k++)
      bad = bad | ((|be[4*k +: 4]) & ~(&be[4*k +: 4]));
    return bad;
  endfunction

  // Number of separate runs of set bits in a word mask.
  function automatic int unsigned run_count(input logic [MAX_DW-1:0] m);
    int unsigned n;
    n = 0;
    for (int k = 0; k < MAX_DW; k++)
      if (m[k] && (k == 0 || !m[k-1])) n++;
    return n;
  endfunction

endpackage

// File: rtl/bbm_beat_tracker.sv
module bbm_beat_tracker #(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic [BURST_W-1:0] burstcnt,
  output logic               first_beat,
  output logic               last_beat,
  output logic               mid_beat
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  logic               in_burst;
  logic [BURST_W-1:0] left_q;
  logic [BURST_W-1:0] load_len;

  assign load_len   = (burstcnt == '0) ? ONE : burstcnt;
  assign first_beat = !in_burst;
  assign last_beat  = first_beat ? (load_len == ONE) : (left_q == ONE);
  assign mid_beat   = !first_beat && !last_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_burst <= 1'b0;
      left_q   <= '0;
    end else if (accept) begin
      in_burst <= !last_beat;
      left_q   <= (first_beat ? load_len : left_q) - ONE;
    end
  end
endmodule

// File: rtl/bbm_be_rules.sv
module bbm_be_rules
  import bbm_pkg::*;
#(
  parameter int BE_W = 16
) (
  input  logic            accept,
  input  logic            mid_beat,
  input  logic [BE_W-1:0] be,
  output logic            v_mid,
  output logic            v_zero,
  output logic            v_split,
  output logic            v_noncontig
);
  logic [MAX_BE-1:0] be_ext;
  assign be_ext = MAX_BE'(be);

  assign v_mid  = accept && mid_beat && !(&be);
  assign v_zero = accept && (be == '0);

  generate
    if (BE_W >= 16) begin : g_wide
      logic [MAX_DW-1:0] wmask;
      assign wmask       = word_any(be_ext);
      assign v_split     = accept && word_split(be_ext);
      assign v_noncontig = accept && (run_count(wmask) > 1);
    end else begin : g_narrow
      logic unused_ok;
      assign unused_ok   = ^be_ext;
      assign v_split     = 1'b0;
      assign v_noncontig = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bbm_stall_watch.sv
module bbm_stall_watch #(
  parameter int REQ_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stalled_req,
  input  logic [REQ_W-1:0] req_bundle,
  output logic             held_q,
  output logic             v_stall
);
  logic [REQ_W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      prev_q <= '0;
    end else begin
      held_q <= stalled_req;
      prev_q <= req_bundle;
    end
  end

  assign v_stall = held_q && (req_bundle != prev_q);
endmodule

// File: rtl/burst_be_monitor.sv
module burst_be_monitor #(
  parameter int DATA_W  = 128,
  parameter int ADDR_W  = 32,
  parameter int BURST_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mon_read,
  input  logic                  mon_write,
  input  logic [ADDR_W-1:0]     mon_addr,
  input  logic [BURST_W-1:0]    mon_burstcnt,
  input  logic [DATA_W-1:0]     mon_wdata,
  input  logic [DATA_W/8-1:0]   mon_be,
  input  logic                  mon_waitreq,
  output logic                  err_mid_beat,
  output logic                  err_dword_split,
  output logic                  err_noncontig,
  output logic                  err_stall_change,
  output logic                  err_zero_be,
  output logic                  err_pulse
);
  localparam int BE_W  = DATA_W / 8;
  localparam int REQ_W = 2 + ADDR_W + BURST_W + DATA_W + BE_W;

  logic accept, first_beat, last_beat, mid_beat, stalled_req, held_q;
  logic v_mid, v_zero, v_split, v_noncontig, v_stall, any_v;

  assign accept      = mon_write && !mon_waitreq;
  assign stalled_req = mon_waitreq && (mon_read || mon_write);

  bbm_beat_tracker #(.BURST_W(BURST_W)) u_track (
    .clk(clk), .rst(rst), .accept(accept), .burstcnt(mon_burstcnt),
    .first_beat(first_beat), .last_beat(last_beat), .mid_beat(mid_beat)
  );

  bbm_be_rules #(.BE_W(BE_W)) u_rules (
    .accept(accept), .mid_beat(mid_beat), .be(mon_be),
    .v_mid(v_mid), .v_zero(v_zero), .v_split(v_split), .v_noncontig(v_noncontig)
  );

  bbm_stall_watch #(.REQ_W(REQ_W)) u_stall (
    .clk(clk), .rst(rst), .stalled_req(stalled_req),
    .req_bundle({mon_read, mon_write, mon_addr, mon_burstcnt, mon_wdata, mon_be}),
    .held_q(held_q), .v_stall(v_stall)
  );

  assign any_v = v_mid | v_zero | v_split | v_noncontig | v_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_mid_beat     <= 1'b0;
      err_dword_split  <= 1'b0;
      err_noncontig    <= 1'b0;
      err_stall_change <= 1'b0;
      err_zero_be      <= 1'b0;
      err_pulse        <= 1'b0;
    end else begin
      err_mid_beat     <= err_mid_beat | v_mid;
      err_dword_split  <= err_dword_split | v_split;
      err_noncontig    <= err_noncontig | v_noncontig;
      err_stall_change <= err_stall_change | v_stall;
      err_zero_be      <= err_zero_be | v_zero;
      err_pulse        <= any_v;
    end
  end
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
  parameter int BE_W    = 16,
  parameter int BURST_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               mon_read,
  input logic               mon_write,
  input logic [BURST_W-1:0] mon_burstcnt,
  input logic [BE_W-1:0]    mon_be,
  input logic               mon_waitreq,
  input logic               accept,
  input logic               first_beat,
  input logic               last_beat,
  input logic               mid_beat,
  input logic               err_mid_beat,
  input logic               err_dword_split,
  input logic               err_noncontig,
  input logic               err_stall_change,
  input logic               err_zero_be,
  input logic               err_pulse
);
  logic [4:0] flags;
  assign flags = {err_mid_beat, err_dword_split, err_noncontig, err_stall_change, err_zero_be};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags == '0 && !err_pulse));

  a_r2_single_is_last: assert property (@(posedge clk) disable iff (rst)
    (accept && first_beat && mon_burstcnt <= BURST_W'(1)) |-> last_beat);

  a_r3_inner_full: assert property (@(posedge clk) disable iff (rst)
    (accept && mid_beat && !(&mon_be)) |=> err_mid_beat);

  a_r5_zero_lanes: assert property (@(posedge clk) disable iff (rst)
    (accept && mon_be == '0) |=> err_zero_be);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(mon_waitreq && (mon_read || mon_write)) &&
     (mon_be != $past(mon_be) || mon_write != $past(mon_write))) |=> err_stall_change);

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags != '0) |=> ((flags & $past(flags)) == $past(flags)));

  a_r11_pulse_has_flag: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (flags != '0));

  generate
    if (BE_W < 16) begin : g_narrow_chk
      a_r9_no_word_rules: assert property (@(posedge clk) disable iff (rst)
        (mon_write && !mon_waitreq) |=> (!err_dword_split && !err_noncontig));
    end
  endgenerate
endmodule

bind burst_be_monitor bbm_checker #(.BE_W(BE_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst(rst), .mon_read(mon_read), .mon_write(mon_write),
  .mon_burstcnt(mon_burstcnt), .mon_be(mon_be), .mon_waitreq(mon_waitreq),
  .accept(accept), .first_beat(first_beat), .last_beat(last_beat), .mid_beat(mid_beat),
  .err_mid_beat(err_mid_beat), .err_dword_split(err_dword_split),
  .err_noncontig(err_noncontig), .err_stall_change(err_stall_change),
  .err_zero_be(err_zero_be), .err_pulse(err_pulse)
);

// File: tb/sim_burst_be_monitor.sv
module sim_burst_be_monitor;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;

  // wide instance
  logic         rd = 0, wr = 0, wq = 0;
  logic [31:0]  addr = 0;
  logic [7:0]   bc = 0;
  logic [127:0] wd = 0;
  logic [15:0]  be = 0;
  logic f_mid, f_split, f_nc, f_stall, f_zero, f_pulse;

  burst_be_monitor #(.DATA_W(128), .ADDR_W(32), .BURST_W(8)) u0 (
    .clk(clk), .rst(rst), .mon_read(rd), .mon_write(wr), .mon_addr(addr),
    .mon_burstcnt(bc), .mon_wdata(wd), .mon_be(be), .mon_waitreq(wq),
    .err_mid_beat(f_mid), .err_dword_split(f_split), .err_noncontig(f_nc),
    .err_stall_change(f_stall), .err_zero_be(f_zero), .err_pulse(f_pulse));

  // narrow instance
  logic        n_wr = 0, n_wq = 0;
  logic [7:0]  n_bc = 0;
  logic [63:0] n_wd = 0;
  logic [7:0]  n_be = 0;
  logic n_mid, n_split, n_nc, n_stall, n_zero, n_pulse;

  burst_be_monitor #(.DATA_W(64), .ADDR_W(32), .BURST_W(8)) u1 (
    .clk(clk), .rst(rst), .mon_read(1'b0), .mon_write(n_wr), .mon_addr(32'h0),
    .mon_burstcnt(n_bc), .mon_wdata(n_wd), .mon_be(n_be), .mon_waitreq(n_wq),
    .err_mid_beat(n_mid), .err_dword_split(n_split), .err_noncontig(n_nc),
    .err_stall_change(n_stall), .err_zero_be(n_zero), .err_pulse(n_pulse));

  // bench model of the wide monitor
  logic [4:0] exp_flags;  // {mid, split, noncontig, stall, zero}
  logic       exp_pulse;
  int         m_left;     // 0 means no burst open
  logic       m_held;
  logic [191:0] m_prev;

  function automatic logic legal_words(input logic [15:0] b);
    logic [3:0] w;
    for (int k = 0; k < 4; k++) w[k] = (b[4*k +: 4] != 4'h0);
    case (w)
      4'h0, 4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'h6, 4'hC, 4'h7, 4'hE, 4'hF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic any_partial(input logic [15:0] b);
    for (int k = 0; k < 4; k++)
      if (b[4*k +: 4] != 4'h0 && b[4*k +: 4] != 4'hF) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: flags+pulse got=%b expected=%b", req, got, want);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rd = 0; wr = 0; wq = 0; be = 0; bc = 0; addr = 0; wd = 0;
    n_wr = 0; n_wq = 0; n_be = 0; n_bc = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
    exp_flags = '0; exp_pulse = 0; m_left = 0; m_held = 0; m_prev = '0;
  endtask

  // one cycle on the wide port, model-checked
  task automatic cyc(input string req, input logic r, input logic w, input logic [7:0] c,
                     input logic [15:0] b, input logic s, input logic [31:0] a);
    logic [4:0] v;
    logic acc, inner;
    logic [191:0] bundle;
    int len;
    @(negedge clk);
    rd = r; wr = w; bc = c; be = b; wq = s; addr = a; wd = {4{a}};
    bundle = {r, w, a, c, wd, b, 6'b0};
    v = '0;
    acc = w && !s;
    if (acc) begin
      len = (c == 0) ? 1 : int'(c);
      inner = (m_left != 0) && (m_left != 1);
      if (inner && b != 16'hFFFF) v[4] = 1;
      if (any_partial(b)) v[3] = 1;
      if (!legal_words(b)) v[2] = 1;
      if (b == 16'h0) v[0] = 1;
      if (m_left == 0) m_left = len - 1; else m_left = m_left - 1;
    end
    if (m_held && bundle != m_prev) v[1] = 1;
    m_held = s && (r || w);
    m_prev = bundle;
    exp_flags = exp_flags | v;
    exp_pulse = |v;
    @(posedge clk); #1;
    check(req, {f_mid, f_split, f_nc, f_stall, f_zero, f_pulse}, {exp_flags, exp_pulse});
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 0, 8'd0, 16'h0, 0, 32'h0);
  endtask

  task automatic t_reset();
    do_reset();
    #1 check("R1", {f_mid, f_split, f_nc, f_stall, f_zero, f_pulse}, 6'b0);
    check("R1", {n_mid, n_split, n_nc, n_stall, n_zero, n_pulse}, 6'b0);
  endtask

  task automatic t_legal_burst();
    do_reset();
    cyc("R4", 0, 1, 8'd4, 16'hFFF0, 0, 32'h100);
    cyc("R3", 0, 1, 8'd4, 16'hFFFF, 0, 32'h100);
    cyc("R3", 0, 1, 8'd4, 16'hFFFF, 0, 32'h100);
    cyc("R4", 0, 1, 8'd4, 16'h00FF, 0, 32'h100);
    idle("R4");
  endtask

  task automatic t_singles();
    do_reset();
    cyc("R2", 0, 1, 8'd1, 16'h0F00, 0, 32'h200);
    cyc("R2", 0, 1, 8'd1, 16'h000F, 0, 32'h204);
    cyc("R2", 0, 1, 8'd0, 16'hF000, 0, 32'h208);
    cyc("R2", 0, 1, 8'd2, 16'h0FF0, 0, 32'h20C);
    cyc("R2", 0, 1, 8'd2, 16'h0FFF, 0, 32'h20C);
  endtask

  task automatic t_mid_bad();
    do_reset();
    cyc("R3", 0, 1, 8'd3, 16'hFFFF, 0, 32'h300);
    cyc("R3", 0, 1, 8'd3, 16'h0FFF, 0, 32'h300);
    cyc("R3", 0, 1, 8'd3, 16'h000F, 0, 32'h300);
    idle("R10");
    idle("R11");
  endtask

  task automatic t_split();
    do_reset();
    cyc("R6", 0, 1, 8'd1, 16'h00F8, 0, 32'h400);
    cyc("R10", 0, 1, 8'd1, 16'hFFFF, 0, 32'h404);
  endtask

  task automatic t_noncontig();
    do_reset();
    cyc("R7", 0, 1, 8'd1, 16'hF00F, 0, 32'h500);
    cyc("R7", 0, 1, 8'd1, 16'h0F0F, 0, 32'h504);
    idle("R10");
  endtask

  task automatic t_zero();
    do_reset();
    cyc("R5", 0, 1, 8'd1, 16'h0000, 0, 32'h600);
    idle("R11");
  endtask

  task automatic t_stall();
    do_reset();
    // legal: stall inside a burst with everything held
    cyc("R8", 0, 1, 8'd3, 16'hFFF0, 0, 32'h700);
    cyc("R8", 0, 1, 8'd3, 16'hFFFF, 1, 32'h700);
    cyc("R8", 0, 1, 8'd3, 16'hFFFF, 1, 32'h700);
    cyc("R2", 0, 1, 8'd3, 16'hFFFF, 0, 32'h700);
    cyc("R2", 0, 1, 8'd3, 16'h0FFF, 0, 32'h700);
    // illegal: lanes change while stalled
    cyc("R8", 0, 1, 8'd1, 16'h00FF, 1, 32'h710);
    cyc("R8", 0, 1, 8'd1, 16'h0FF0, 0, 32'h710);
    // read request dropped while stalled
    do_reset();
    cyc("R8", 1, 0, 8'd1, 16'h0, 1, 32'h720);
    cyc("R8", 0, 0, 8'd1, 16'h0, 0, 32'h720);
  endtask

  task automatic ncyc(input logic [7:0] c, input logic [7:0] b);
    @(negedge clk);
    n_wr = 1; n_wq = 0; n_bc = c; n_be = b; n_wd = {8{b}};
    @(posedge clk); #1;
  endtask

  task automatic t_narrow();
    do_reset();
    ncyc(8'd1, 8'h5A);
    check("R9", {n_mid, n_split, n_nc, n_stall, n_zero, n_pulse}, 6'b0);
    ncyc(8'd1, 8'h81);
    check("R9", {n_mid, n_split, n_nc, n_stall, n_zero, n_pulse}, 6'b0);
    ncyc(8'd3, 8'hF0);
    ncyc(8'd3, 8'h7F);
    check("R3", {n_mid, n_split, n_nc, n_stall, n_zero, n_pulse}, 6'b100001);
    @(negedge clk); n_wr = 0;
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_legal_burst();
    t_singles();
    t_mid_bad();
    t_split();
    t_noncontig();
    t_zero();
    t_stall();
    t_narrow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule